// File: doc/BRIEF.md
# Universal Word Selector with Zero Flag

This block chooses between two operand words, `a_word` and `b_word`, and places the result on a shared output bus. A two-bit mode input selects the A word, the B word, the bitwise AND of both (so one operand masks the other), or a cleared word. An inversion input then passes the result through unchanged or sends out its bitwise complement. A zero flag reports whether the operand chosen in the two pass modes is entirely zero. Every output is registered on the rising clock edge, so each result appears one cycle after its inputs are sampled.

The outputs behave as tri-state bus drivers. A single input combination, clear mode together with inversion, releases both the data bus and the flag. A separate `out_en` port shows the registered drive condition, so neighbouring logic can see when the bus is released. The word width is a parameter. Several instances can be chained to cover a wider word: each stage takes a `zero_in` input and ANDs it into its own flag, so the last stage reports zero for the whole word.

Top module: `umux`

## Requirements
- R1: While `rst` is high at a rising edge, the next state releases the bus: `out_en` reads 0, and `y_out` and `zero_out` are high impedance.
- R2: With `sel` = 2'b00 and `invert` = 0, `y_out` equals the `a_word` sampled at the previous rising edge and `out_en` is 1.
- R3: With `sel` = 2'b01 and `invert` = 0, `y_out` equals the previously sampled `b_word`.
- R4: With `sel` = 2'b10 and `invert` = 0, `y_out` equals the bitwise AND of the previously sampled `a_word` and `b_word`.
- R5: With `sel` = 2'b11 and `invert` = 0, `y_out` is driven to all zeros whatever the operands are.
- R6: With `invert` = 1 and `sel` in 2'b00, 2'b01 or 2'b10, `y_out` is the bitwise complement of the result that R2, R3 or R4 describe.
- R7: With `sel` = 2'b11 and `invert` = 1, `out_en` reads 0 on the next cycle and both `y_out` and `zero_out` are high impedance. In every other combination `out_en` reads 1 and both outputs are driven.
- R8: In the pass modes (`sel[1]` = 0), `zero_out` is 1 exactly when every bit of the selected operand was 0 and `zero_in` was 1. The value of `invert` has no effect on the flag.
- R9: In the mask mode and in driven clear mode (`sel[1]` = 1), `zero_out` is driven to 0 whatever the operand contents and `zero_in` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_word | input | WIDTH | First operand |
| b_word | input | WIDTH | Second operand |
| sel | input | 2 | Mode: 00 A, 01 B, 10 A AND B, 11 clear |
| invert | input | 1 | 1 complements the result |
| zero_in | input | 1 | Zero flag from the previous chained stage (tie to 1 when unused) |
| y_out | output | WIDTH | Result bus, tri-state |
| zero_out | output | 1 | Zero flag, tri-state |
| out_en | output | 1 | Registered drive condition of both outputs |

## Verification
Two functions meet in the same cycle when clear mode and inversion are asserted together. Complementing the cleared word would give all ones, but the bus release has to win. The bench drives `sel` = 2'b11 with `invert` = 1 over non-zero operands. It judges the result from `out_en`, and in the next cycle it drops `invert` to confirm that the bus is driven again, with zeros. The zero flag and inversion also meet in one cycle: pass modes are run with `invert` high, and the flag must still follow the operand rather than the complemented bus.

// File: rtl/umux_pkg.sv
package umux_pkg;

  typedef enum logic [1:0] {
    MODE_PASS_A = 2'b00,
    MODE_PASS_B = 2'b01,
    MODE_MASK   = 2'b10,
    MODE_CLEAR  = 2'b11
  } umux_mode_e;

  // Bus release condition: clear mode combined with inversion.
  function automatic logic release_bus(input umux_mode_e mode, input logic inv);
    return (mode == MODE_CLEAR) && inv;
  endfunction

  // Zero flag is meaningful only in the pass modes.
  function automatic logic flag_valid(input umux_mode_e mode);
    return (mode == MODE_PASS_A) || (mode == MODE_PASS_B);
  endfunction

endpackage

// File: rtl/umux_datapath.sv
module umux_datapath
  import umux_pkg::*;
#(
  parameter int WIDTH = 6
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  umux_mode_e       mode_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] res_o
);

  logic [WIDTH-1:0] pre_inv;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (mode_i)
        MODE_PASS_A: pre_inv[i] = a_i[i];
        MODE_PASS_B: pre_inv[i] = b_i[i];
        MODE_MASK:   pre_inv[i] = a_i[i] & b_i[i];
        default:     pre_inv[i] = 1'b0;
      endcase
    end
    assign res_o[i] = pre_inv[i] ^ inv_i;
  end

endmodule

// File: rtl/umux_zero_det.sv
module umux_zero_det
  import umux_pkg::*;
#(
  parameter int WIDTH = 6
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  umux_mode_e       mode_i,
  input  logic             chain_i,
  output logic             zero_o
);

  logic [WIDTH-1:0] operand;
  logic             all_low;

  assign operand = (mode_i == MODE_PASS_B) ? b_i : a_i;
  assign all_low = ~|operand;
  assign zero_o  = flag_valid(mode_i) & all_low & chain_i;

endmodule

// File: rtl/umux_out_stage.sv
module umux_out_stage #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] res_i,
  input  logic             zero_i,
  input  logic             drive_i,
  output wire  [WIDTH-1:0] y_o,
  output wire              zero_o,
  output wire              en_o
);

  logic [WIDTH-1:0] res_q;
  logic             zero_q;
  logic             en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      zero_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      res_q  <= res_i;
      zero_q <= zero_i;
      en_q   <= drive_i;
    end
  end

  assign y_o    = en_q ? res_q  : {WIDTH{1'bz}};
  assign zero_o = en_q ? zero_q : 1'bz;
  assign en_o   = en_q;

endmodule

// File: rtl/umux.sv
module umux
  import umux_pkg::*;
#(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_word,
  input  logic [WIDTH-1:0] b_word,
  input  logic [1:0]       sel,
  input  logic             invert,
  input  logic             zero_in,
  output wire  [WIDTH-1:0] y_out,
  output wire              zero_out,
  output wire              out_en
);

  umux_mode_e       mode;
  logic [WIDTH-1:0] result;
  logic             zero_flag;
  logic             drive;

  assign mode  = umux_mode_e'(sel);
  assign drive = ~release_bus(mode, invert);

  umux_datapath #(.WIDTH(WIDTH)) u_data (
    .a_i    (a_word),
    .b_i    (b_word),
    .mode_i (mode),
    .inv_i  (invert),
    .res_o  (result)
  );

  umux_zero_det #(.WIDTH(WIDTH)) u_zero (
    .a_i     (a_word),
    .b_i     (b_word),
    .mode_i  (mode),
    .chain_i (zero_in),
    .zero_o  (zero_flag)
  );

  umux_out_stage #(.WIDTH(WIDTH)) u_out (
    .clk     (clk),
    .rst     (rst),
    .res_i   (result),
    .zero_i  (zero_flag),
    .drive_i (drive),
    .y_o     (y_out),
    .zero_o  (zero_out),
    .en_o    (out_en)
  );

endmodule

// File: rtl/umux_chk.sv
module umux_chk #(
  parameter int WIDTH = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_word,
  input logic [WIDTH-1:0] b_word,
  input logic [1:0]       sel,
  input logic             invert,
  input logic             zero_in,
  input logic [WIDTH-1:0] y_out,
  input logic             zero_out,
  input logic             out_en
);

  logic past_rst = 1'b0;
  always_ff @(posedge clk) past_rst <= rst;

  // R1: a reset edge leaves the bus released
  always @(posedge clk) begin
    if (past_rst === 1'b1) begin
      assert_reset_release_R1: assert (out_en == 1'b0);
    end
  end

  assert_pass_a_R2: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b00 && !invert) |=> (out_en && y_out == $past(a_word)));

  assert_pass_b_R3: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b01 && !invert) |=> (out_en && y_out == $past(b_word)));

  assert_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b10 && !invert) |=> (y_out == ($past(a_word) & $past(b_word))));

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b11 && !invert) |=> (out_en && y_out == '0));

  assert_invert_a_R6: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b00 && invert) |=> (y_out == ~$past(a_word)));

  assert_release_R7: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b11 && invert) |=> !out_en);

  assert_driven_R7: assert property (@(posedge clk) disable iff (rst)
    !(sel == 2'b11 && invert) |=> out_en);

  assert_flag_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b00) |=> (zero_out == ((~|$past(a_word)) && $past(zero_in))));

  assert_flag_low_R9: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b10) |=> (zero_out == 1'b0));

endmodule

bind umux umux_chk #(.WIDTH(WIDTH)) u_umux_chk (
  .clk      (clk),
  .rst      (rst),
  .a_word   (a_word),
  .b_word   (b_word),
  .sel      (sel),
  .invert   (invert),
  .zero_in  (zero_in),
  .y_out    (y_out),
  .zero_out (zero_out),
  .out_en   (out_en)
);

// File: tb/tb_umux.sv
`timescale 1ns/1ps
module tb_umux;

  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_word = '0;
  logic [W-1:0] b_word = '0;
  logic [1:0]   sel = 2'b00;
  logic         invert = 1'b0;
  logic         zero_in = 1'b1;
  wire  [W-1:0] y_out;
  wire          zero_out;
  wire          out_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  umux #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .a_word(a_word), .b_word(b_word), .sel(sel),
    .invert(invert), .zero_in(zero_in), .y_out(y_out), .zero_out(zero_out),
    .out_en(out_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge register it, sample 1 ns later.
  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [1:0] s, input logic inv, input logic zi);
    @(negedge clk);
    a_word = a; b_word = b; sel = s; invert = inv; zero_in = zi;
    @(posedge clk);
    #1;
  endtask

  // Full comparison against a model built from the requirements.
  task automatic run_and_compare(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                                 input logic [1:0] s, input logic inv, input logic zi);
    logic [W-1:0] r;
    logic         en;
    logic         z;
    apply(a, b, s, inv, zi);
    case (s)
      2'b00:   r = a;
      2'b01:   r = b;
      2'b10:   r = a & b;
      default: r = '0;
    endcase
    if (inv) r = ~r;
    en = !(s == 2'b11 && inv);
    z  = (s[1] == 1'b0) && ((s[0] ? b : a) == '0) && zi;
    check({req, " R7 en"}, 32'(out_en), 32'(en));
    if (en) begin
      check({req, " y"}, 32'(y_out), 32'(r));
      check({req, " flag"}, 32'(zero_out), 32'(z));
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    rst = 1'b1; sel = 2'b00; a_word = 6'h2a; invert = 1'b0;
    @(posedge clk); #1;
    check("R1 reset en", 32'(out_en), 32'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic test_pass_a();
    run_and_compare("R2 pass A", 6'h2d, 6'h12, 2'b00, 1'b0, 1'b1);
    run_and_compare("R2 pass A all ones", 6'h3f, 6'h00, 2'b00, 1'b0, 1'b1);
  endtask

  task automatic test_pass_b();
    run_and_compare("R3 pass B", 6'h01, 6'h35, 2'b01, 1'b0, 1'b1);
  endtask

  task automatic test_mask();
    run_and_compare("R4 mask", 6'h3c, 6'h0f, 2'b10, 1'b0, 1'b1);
  endtask

  task automatic test_clear();
    run_and_compare("R5 clear", 6'h3f, 6'h3f, 2'b11, 1'b0, 1'b1);
    run_and_compare("R9 clear flag", 6'h00, 6'h00, 2'b11, 1'b0, 1'b1);
  endtask

  task automatic test_invert();
    run_and_compare("R6 inv A", 6'h05, 6'h00, 2'b00, 1'b1, 1'b1);
    run_and_compare("R6 inv B", 6'h00, 6'h21, 2'b01, 1'b1, 1'b1);
    run_and_compare("R6 inv mask", 6'h33, 6'h1e, 2'b10, 1'b1, 1'b1);
  endtask

  task automatic test_release();
    apply(6'h15, 6'h2a, 2'b11, 1'b1, 1'b1);
    check("R7 release", 32'(out_en), 32'd0);
    apply(6'h15, 6'h2a, 2'b11, 1'b0, 1'b1);
    check("R7 redriven", 32'(out_en), 32'd1);
    check("R5 redriven zeros", 32'(y_out), 32'd0);
  endtask

  task automatic test_zero_flag();
    run_and_compare("R8 A zero", 6'h00, 6'h3f, 2'b00, 1'b0, 1'b1);
    run_and_compare("R8 B zero", 6'h3f, 6'h00, 2'b01, 1'b0, 1'b1);
    run_and_compare("R8 A zero inverted", 6'h00, 6'h11, 2'b00, 1'b1, 1'b1);
    run_and_compare("R8 A nonzero", 6'h20, 6'h00, 2'b00, 1'b0, 1'b1);
    run_and_compare("R9 mask zero", 6'h00, 6'h00, 2'b10, 1'b0, 1'b1);
  endtask

  task automatic test_chain();
    run_and_compare("R8 chain low", 6'h00, 6'h00, 2'b00, 1'b0, 1'b0);
    run_and_compare("R8 chain low B", 6'h00, 6'h00, 2'b01, 1'b1, 1'b0);
  endtask

  task automatic test_sweep();
    for (int s = 0; s < 4; s++) begin
      for (int inv = 0; inv < 2; inv++) begin
        for (int k = 0; k < 6; k++) begin
          logic [W-1:0] a;
          logic [W-1:0] b;
          a = (k == 0) ? '0 : W'($urandom);
          b = (k == 1) ? '0 : W'($urandom);
          run_and_compare("R6 sweep", a, b, 2'(s), 1'(inv), 1'($urandom));
        end
      end
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    test_reset();
    test_pass_a();
    test_pass_b();
    test_mask();
    test_clear();
    test_invert();
    test_release();
    test_zero_flag();
    test_chain();
    test_sweep();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule